// File: doc/BRIEF.md
# Three-Channel Residue Scaler

This block divides an integer by a fixed constant while the integer is still held as residues. The integer X is given by its remainders modulo 2^N+1, 2^N and 2^N−1. The constant is 2^N·(2^N+1). The block returns one N-bit value Y that approximates floor(X / (2^N·(2^N+1))). Because Y is never larger than 2^N−2, the same value is the residue of the quotient in all three channels. It is also the ordinary binary quotient, so no conversion back to binary is needed after scaling.

The arithmetic needs no lookup tables. The datapath first folds the wide residue and builds four operands by complementing and rotating bits. Two carry-save levels then reduce the four operands to two, wrapping each carry-out back into bit 0. A modulo 2^N−1 adder produces the result and maps an all-ones sum to zero. A parameter selects whether the result is registered on the clock or taken straight from the adder. A typical use is after each multiply-accumulate stage of a residue datapath, to keep values inside the dynamic range.

Top module: `rns_scaler3`

## Requirements
- R1: `quot` is congruent modulo 2^N−1 to r1 − r2 + 2^(N−1)·(r3 − r1). Here r1 is `res_plus`, r2 is `res_pow` and r3 is `res_minus`.
- R2: When `res_pow` ≥ `res_plus`, `quot` equals floor(X / (2^N·(2^N+1))) exactly.
- R3: When `res_pow` < `res_plus`, `quot` equals (floor(X / (2^N·(2^N+1))) + 1) mod (2^N−1). This is one above the exact quotient, except at quotient 2^N−2, which wraps to 0.
- R4: `quot` never takes the all-ones value. It always lies in 0..2^N−2.
- R5: `res_plus` is N+1 bits wide and accepts the value 2^N. Bit N has weight 1 modulo 2^N−1.
- R6: Giving `res_minus` as all ones gives the same `quot` as giving it as zero.
- R7: For N = 5, the residues (`res_plus`, `res_pow`, `res_minus`) = (2, 14, 5), which stand for X = 5678, give `quot` = 5.
- R8: With OUT_REG = 1, `quot` shows the result of the inputs sampled at the previous rising edge of `clk`. It holds that value while the inputs change between edges. With OUT_REG = 0, `quot` is combinational.
- R9: With OUT_REG = 1, `rst_n` low clears `quot` to 0 at once, without waiting for a clock edge, and holds it at 0 across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_plus | input | N+1 | X mod (2^N+1), value 0..2^N |
| res_pow | input | N | X mod 2^N |
| res_minus | input | N | X mod (2^N−1); all ones stands for zero |
| quot | output | N | Scaled value, shared by all three channels |

## Verification
Every X in the dynamic range for N = 5 is turned into its three residues and scaled. The result is compared against the floor quotient computed from X. This separates the exact cases (R2) from the plus-one cases (R3), and it reaches the single wrap to 0 at the top of the range. A short table of hand-worked vectors pins down the stated example, the value 2^N in the wide residue, and the boundaries at a multiple of the constant and one below it. Directed steps give the zero in the smallest channel in its all-ones form. They also show that the registered output holds between edges and that reset clears it immediately.

// File: rtl/rns_scale_pkg.sv
`timescale 1ns/1ps
package rns_scale_pkg;

  // Largest channel width the check arithmetic is sized for
  localparam int unsigned NMAX = 16;

  // Non-negative remainder of v modulo 2^w - 1
  function automatic longint modm(longint v, int unsigned w);
    longint m;
    longint r;
    m = (longint'(1) << w) - 1;
    r = v % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  // Value of an all-ones word of w bits
  function automatic longint ones_val(int unsigned w);
    return (longint'(1) << w) - 1;
  endfunction

endpackage

// File: rtl/rns_operand_prep.sv
`timescale 1ns/1ps
module rns_operand_prep #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N:0]   res_plus,
  input  logic [N-1:0] res_pow,
  input  logic [N-1:0] res_minus,
  output logic [N-1:0] op_a,
  output logic [N-1:0] op_b,
  output logic [N-1:0] op_c,
  output logic [N-1:0] op_d
);
  import rns_scale_pkg::*;

  localparam int unsigned ROT = N - 1;

  logic [N-1:0] plus_fold;   // res_plus reduced into N bits
  logic [N-1:0] plus_neg;    // negation of plus_fold modulo 2^N-1

  // Bit N is set only for the value 2^N (low bits zero); 2^N == 1 mod 2^N-1
  assign plus_fold = res_plus[N-1:0] | {{(N-1){1'b0}}, res_plus[N]};
  assign plus_neg  = ~plus_fold;

  assign op_a = plus_fold;
  assign op_b = ~res_pow;

  // Multiply by 2^(N-1) modulo 2^N-1: rotate left by N-1
  for (genvar i = 0; i < N; i++) begin : g_rot
    assign op_c[(i + ROT) % N] = res_minus[i];
    assign op_d[(i + ROT) % N] = plus_neg[i];
  end

  AST_FOLD_CONGRUENT: assert property (@(posedge clk) disable iff (!rst_n)
    modm(longint'(plus_fold), N) == modm(longint'(res_plus), N)); // R5

endmodule

// File: rtl/rns_csa_eac.sv
`timescale 1ns/1ps
module rns_csa_eac #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  input  logic [N-1:0] in_c,
  output logic [N-1:0] out_sum,
  output logic [N-1:0] out_cry
);
  import rns_scale_pkg::*;

  logic [N-1:0] maj;

  assign out_sum = in_a ^ in_b ^ in_c;
  assign maj     = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);

  // Carry of bit N-1 has weight 2^N == 1, so it re-enters at bit 0
  for (genvar i = 0; i < N; i++) begin : g_wrap
    assign out_cry[(i + 1) % N] = maj[i];
  end

  AST_CSA_CONGRUENT: assert property (@(posedge clk) disable iff (!rst_n)
    modm(longint'(out_sum) + longint'(out_cry), N) ==
    modm(longint'(in_a) + longint'(in_b) + longint'(in_c), N)); // R1

endmodule

// File: rtl/rns_mod_adder.sv
`timescale 1ns/1ps
module rns_mod_adder #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] add_a,
  input  logic [N-1:0] add_b,
  output logic [N-1:0] add_y
);
  import rns_scale_pkg::*;

  logic [N:0]   raw_sum;
  logic [N-1:0] wrapped;
  logic         is_ones;

  assign raw_sum = {1'b0, add_a} + {1'b0, add_b};
  // If the carry-out is set the low part is at most 2^N-2, so this cannot overflow
  assign wrapped = raw_sum[N-1:0] + {{(N-1){1'b0}}, raw_sum[N]};
  assign is_ones = &wrapped;
  assign add_y   = is_ones ? '0 : wrapped;

  AST_MODADD_CONGRUENT: assert property (@(posedge clk) disable iff (!rst_n)
    modm(longint'(add_y), N) ==
    modm(longint'(add_a) + longint'(add_b), N)); // R1

endmodule

// File: rtl/rns_scaler3.sv
`timescale 1ns/1ps
module rns_scaler3 #(
  parameter int unsigned N       = 5,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N:0]   res_plus,
  input  logic [N-1:0] res_pow,
  input  logic [N-1:0] res_minus,
  output logic [N-1:0] quot
);
  import rns_scale_pkg::*;

  localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

  logic [N-1:0] op_a, op_b, op_c, op_d;
  logic [N-1:0] lvl1_sum, lvl1_cry;
  logic [N-1:0] lvl2_sum, lvl2_cry;
  logic [N-1:0] y_comb;

  rns_operand_prep #(.N(N)) u_prep (
    .clk(clk), .rst_n(rst_n),
    .res_plus(res_plus), .res_pow(res_pow), .res_minus(res_minus),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d)
  );

  rns_csa_eac #(.N(N)) u_csa1 (
    .clk(clk), .rst_n(rst_n),
    .in_a(op_a), .in_b(op_b), .in_c(op_c),
    .out_sum(lvl1_sum), .out_cry(lvl1_cry)
  );

  rns_csa_eac #(.N(N)) u_csa2 (
    .clk(clk), .rst_n(rst_n),
    .in_a(lvl1_sum), .in_b(lvl1_cry), .in_c(op_d),
    .out_sum(lvl2_sum), .out_cry(lvl2_cry)
  );

  rns_mod_adder #(.N(N)) u_cpa (
    .clk(clk), .rst_n(rst_n),
    .add_a(lvl2_sum), .add_b(lvl2_cry),
    .add_y(y_comb)
  );

  if (OUT_REG) begin : g_reg
    logic [N-1:0] quot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quot_q <= '0;
      else        quot_q <= y_comb;
    end
    assign quot = quot_q;

    AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> quot == $past(y_comb)); // R8
  end else begin : g_comb
    assign quot = y_comb;
  end

  AST_NO_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    quot != ALL_ONES); // R4

  AST_PATH_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    modm(longint'(y_comb), N) ==
    modm(longint'(op_a) + longint'(op_b) + longint'(op_c) + longint'(op_d), N)); // R1

endmodule

// File: tb/test_rns_scaler3.sv
`timescale 1ns/1ps
module test_rns_scaler3;

  localparam int N      = 5;
  localparam int PPOW   = 1 << N;
  localparam int PPLUS  = PPOW + 1;
  localparam int PMINUS = PPOW - 1;
  localparam int KSCALE = PPOW * PPLUS;
  localparam int RANGE  = PPLUS * PPOW * PMINUS;
  localparam int WDOG   = 150000;

  // Hand-worked vectors: res_plus, res_pow, res_minus, expected quot
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{ 2, 14,  5,  5},   // X = 5678, stated example (R7)
    '{ 0,  0,  0,  0},   // X = 0 (R2)
    '{32, 31, 30,  0},   // X = top of range, quotient 30 wraps to 0 (R3)
    '{ 0,  0,  2,  1},   // X = 1056, one full constant (R2)
    '{32, 31,  1,  1},   // X = 1055, r1 = 2^N, plus one (R3, R5)
    '{32,  0,  1,  1}    // X = 32, r1 = 2^N (R5)
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N:0]   res_plus;
  logic [N-1:0] res_pow;
  logic [N-1:0] res_minus;
  logic [N-1:0] quot;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rns_scaler3 #(.N(N), .OUT_REG(1'b1)) i_rns_scaler3 (
    .clk(clk), .rst_n(rst_n),
    .res_plus(res_plus), .res_pow(res_pow), .res_minus(res_minus),
    .quot(quot)
  );

  function automatic int ref_quot(int x);
    int q;
    q = x / KSCALE;
    if ((x % PPOW) < (x % PPLUS)) q = (q + 1) % PMINUS;
    return q;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(int a, int b, int c);
    @(negedge clk);
    res_plus  = (N+1)'(a);
    res_pow   = N'(b);
    res_minus = N'(c);
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n     = 1'b0;
    res_plus  = 6'd2;
    res_pow   = 5'd14;
    res_minus = 5'd5;
    #1;
    check("R9 reset value", int'(quot), 0);
    repeat (2) @(posedge clk);
    #1;
    check("R9 held in reset across edges", int'(quot), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table of worked vectors
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][0], VEC[v][1], VEC[v][2]);
      check($sformatf("R7/R2/R3/R5 vector %0d", v), int'(quot), VEC[v][3]);
    end

    // Whole dynamic range
    begin
      int bad_ones = 0;
      for (int x = 0; x < RANGE; x++) begin
        int a, b, c, e;
        a = x % PPLUS;
        b = x % PPOW;
        c = x % PMINUS;
        apply(a, b, c);
        e = ref_quot(x);
        if (b >= a) check($sformatf("R1 R2 X=%0d", x), int'(quot), e);
        else        check($sformatf("R1 R3 X=%0d", x), int'(quot), e);
        if (int'(quot) == PMINUS) bad_ones++;
      end
      check("R4 all-ones outputs seen", bad_ones, 0);
    end

    // Zero in the smallest channel given as all ones
    for (int k = 0; k < 20; k++) begin
      int x;
      x = k * 1581;
      apply(x % PPLUS, x % PPOW, PMINUS);
      check($sformatf("R6 X=%0d", x), int'(quot), ref_quot(x));
    end

    // Output register holds between edges
    apply(2, 14, 5);
    check("R8 registered result", int'(quot), 5);
    @(negedge clk);
    res_plus  = 6'd32;
    res_pow   = 5'd0;
    res_minus = 5'd1;
    #1;
    check("R8 hold before edge", int'(quot), 5);
    @(posedge clk);
    #1;
    check("R8 update after edge", int'(quot), 1);

    // Asynchronous reset mid-run
    apply(2, 14, 5);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R9 async clear", int'(quot), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(0, 0, 2);
    check("R9 resume after reset", int'(quot), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule